// File: doc/BRIEF.md
# Two-Contact Changeover Switch Debouncer

This block cleans up a changeover switch whose two contacts, the one that closes on operation (the make contact) and the one that opens on operation (the break contact), reach the chip as separate active-low lines. Each line first passes through a two-stage synchronizer. A free-running divider then produces a sampling tick every `TICK_CYCLES` clock cycles, and the contacts are looked at only on that tick.

The state machine trusts each contact only for the transition that contact can legitimately cause. While the switch is released, only a falling edge on the make contact can move it to pressed. While pressed, only a falling edge on the break contact can move it back to released. Bounces on the contact that has just fired are therefore ignored. A later bounce on that contact cannot reverse the decision, because only the opposite contact can do that.

A tick on which both contacts read low is physically impossible, so the block treats it as invalid and discards it. An optional confirmation mode requires a falling level to hold for two consecutive ticks, which rejects a single noisy sample. Each accepted change raises a one-cycle `press_pulse` or `release_pulse`.

Top module: `spdt_debounce`

## Requirements
- R1: Synchronous active-high reset puts the switch in the released state (`sw_active` = 0) with both pulses low. The contact history is reset to the resting levels: make contact high, break contact low.
- R2: While released, a tick on which the synchronized make contact reads 0, after it read 1 on the previous tick, sets `sw_active` to 1 and raises `press_pulse`. Both take effect in the cycle after that tick.
- R3: While pressed, a tick on which the synchronized break contact reads 0, after it read 1 on the previous tick, clears `sw_active` and raises `release_pulse`. Both take effect in the cycle after that tick.
- R4: A falling edge on the make contact while pressed has no effect. A falling edge on the break contact while released has no effect.
- R5: A tick on which both contacts read 0 changes neither the state nor the pulses, even if it carries a falling edge.
- R6: With `CONFIRM` = 1, an edge counts only if the contact read 1, then 0, then 0 on three consecutive ticks. A single low tick between high ticks is ignored.
- R7: Contacts are evaluated only on the tick, which occurs once every `TICK_CYCLES` clock cycles. `sw_active` changes only in the cycle after a tick.
- R8: Each pulse lasts exactly one clock cycle, and `press_pulse` and `release_pulse` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| make_n | input | 1 | Asynchronous make contact, low when the switch is operated |
| break_n | input | 1 | Asynchronous break contact, low when the switch is at rest |
| sw_active | output | 1 | Debounced switch state, 1 = pressed |
| press_pulse | output | 1 | One-cycle pulse on entering the pressed state |
| release_pulse | output | 1 | One-cycle pulse on entering the released state |

## Verification
A corrupted state register appears at `sw_active` at once, in the cycle after the tick that wrote it. The pulses reveal it on the next accepted edge: either they are missing, or the one that fires belongs to the wrong contact. A corrupted contact history is more hidden. It shows up only on the following tick, or the one after that when confirmation is enabled, as a press or release that arrives one tick early or late. For that reason the bench compares state and pulses after every tick against a tick-level model, running both confirmation settings side by side on the same stimulus.

// File: rtl/spdt_pkg.sv
package spdt_pkg;

    typedef enum logic {
        SW_OFF = 1'b0,
        SW_ON  = 1'b1
    } sw_state_e;

    // Bit order matters: the top indexes contacts by these positions.
    typedef struct packed {
        logic mk;   // make contact, active low
        logic bk;   // break contact, active low
    } contact_s;

    localparam int IDX_MK = 1;
    localparam int IDX_BK = 0;
    localparam logic [1:0] REST_LEVELS = 2'b10;  // make high, break low at rest

    function automatic logic fall_plain(input logic h1, input logic cur);
        return h1 & ~cur;
    endfunction

    function automatic logic fall_confirmed(input logic h2, input logic h1, input logic cur);
        return h2 & ~h1 & ~cur;
    endfunction

    function automatic logic both_closed(input contact_s c);
        return ~c.mk & ~c.bk;
    endfunction

endpackage

// File: rtl/spdt_sync.sv
module spdt_sync #(
    parameter int              WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/spdt_tick.sv
module spdt_tick #(
    parameter int PERIOD = 100000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt;

    assign tick = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/spdt_edge.sv
module spdt_edge
    import spdt_pkg::*;
#(
    parameter bit RST_LVL = 1'b1,
    parameter bit CONFIRM = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic level,
    output logic fall
);
    logic h1;

    always_ff @(posedge clk) begin
        if (rst)       h1 <= RST_LVL;
        else if (tick) h1 <= level;
    end

    generate
        if (CONFIRM) begin : g_confirm
            logic h2;
            always_ff @(posedge clk) begin
                if (rst)       h2 <= RST_LVL;
                else if (tick) h2 <= h1;
            end
            assign fall = tick & fall_confirmed(h2, h1, level);
        end else begin : g_plain
            assign fall = tick & fall_plain(h1, level);
        end
    endgenerate
endmodule

// File: rtl/spdt_debounce.sv
module spdt_debounce
    import spdt_pkg::*;
#(
    parameter int TICK_CYCLES = 100000,
    parameter bit CONFIRM     = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic make_n,
    input  logic break_n,
    output logic sw_active,
    output logic press_pulse,
    output logic release_pulse
);
    contact_s   raw;
    contact_s   lvl_sync;
    logic       tick;
    logic [1:0] fall;
    sw_state_e  state;

    assign raw.mk = make_n;
    assign raw.bk = break_n;

    spdt_sync #(.WIDTH(2), .RST_VAL(REST_LEVELS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (lvl_sync)
    );

    spdt_tick #(.PERIOD(TICK_CYCLES)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    for (genvar i = 0; i < 2; i++) begin : g_contact
        spdt_edge #(.RST_LVL(REST_LEVELS[i]), .CONFIRM(CONFIRM)) u_edge (
            .clk   (clk),
            .rst   (rst),
            .tick  (tick),
            .level (lvl_sync[i]),
            .fall  (fall[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= SW_OFF;
            press_pulse   <= 1'b0;
            release_pulse <= 1'b0;
        end else begin
            press_pulse   <= 1'b0;
            release_pulse <= 1'b0;
            if (tick && !both_closed(lvl_sync)) begin
                unique case (state)
                    SW_OFF: if (fall[IDX_MK]) begin
                        state       <= SW_ON;
                        press_pulse <= 1'b1;
                    end
                    SW_ON: if (fall[IDX_BK]) begin
                        state         <= SW_OFF;
                        release_pulse <= 1'b1;
                    end
                    default: state <= SW_OFF;
                endcase
            end
        end
    end

    assign sw_active = (state == SW_ON);
endmodule

// File: rtl/spdt_debounce_chk.sv
module spdt_debounce_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic [1:0] lvl,
    input logic       sw_active,
    input logic       press_pulse,
    input logic       release_pulse
);
    AST_PRESS_ON_ENTRY: assert property (@(posedge clk) disable iff (rst)
        $rose(sw_active) |-> press_pulse); // R2

    AST_ENTRY_NEEDS_MAKE: assert property (@(posedge clk) disable iff (rst)
        $rose(sw_active) |-> $past(tick && !lvl[1] && lvl[0])); // R2

    AST_RELEASE_ON_EXIT: assert property (@(posedge clk) disable iff (rst)
        $fell(sw_active) |-> release_pulse); // R3

    AST_EXIT_NEEDS_BREAK: assert property (@(posedge clk) disable iff (rst)
        $fell(sw_active) |-> $past(tick && !lvl[0] && lvl[1])); // R3

    AST_PRESS_ONLY_IF_ON: assert property (@(posedge clk) disable iff (rst)
        press_pulse |-> sw_active); // R4

    AST_RELEASE_ONLY_IF_OFF: assert property (@(posedge clk) disable iff (rst)
        release_pulse |-> !sw_active); // R4

    AST_BOTH_LOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        (tick && !lvl[0] && !lvl[1]) |=> ($stable(sw_active) && !press_pulse && !release_pulse)); // R5

    AST_CHANGE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(sw_active)); // R7

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(press_pulse && release_pulse)); // R8

    AST_PRESS_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        press_pulse |=> !press_pulse); // R8

    AST_RELEASE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        release_pulse |=> !release_pulse); // R8
endmodule

bind spdt_debounce spdt_debounce_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .tick          (tick),
    .lvl           (lvl_sync),
    .sw_active     (sw_active),
    .press_pulse   (press_pulse),
    .release_pulse (release_pulse)
);

// File: tb/sim_spdt_debounce.sv
module sim_spdt_debounce;
    localparam int T = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       make_n = 1'b1;
    logic       break_n = 1'b0;
    logic [1:0] act, pr, rl;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state, index = confirm setting
    logic m_st [2];
    logic m_pr [2];
    logic m_rl [2];
    logic mk1 [2], mk2 [2], bk1 [2], bk2 [2];

    always #5 clk = ~clk;

    spdt_debounce #(.TICK_CYCLES(T), .CONFIRM(1'b0)) u0 (
        .clk(clk), .rst(rst), .make_n(make_n), .break_n(break_n),
        .sw_active(act[0]), .press_pulse(pr[0]), .release_pulse(rl[0]));

    spdt_debounce #(.TICK_CYCLES(T), .CONFIRM(1'b1)) u1 (
        .clk(clk), .rst(rst), .make_n(make_n), .break_n(break_n),
        .sw_active(act[1]), .press_pulse(pr[1]), .release_pulse(rl[1]));

    function automatic logic fell_m(input logic conf, input logic h2, input logic h1, input logic cur);
        return conf ? (h2 & ~h1 & ~cur) : (h1 & ~cur);
    endfunction

    task automatic check(input logic got, input logic exp, input string tag, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            m_st[c] = 1'b0; m_pr[c] = 1'b0; m_rl[c] = 1'b0;
            mk1[c] = 1'b1; mk2[c] = 1'b1; bk1[c] = 1'b0; bk2[c] = 1'b0;
        end
    endtask

    task automatic model_tick(input logic mk, input logic bk);
        for (int c = 0; c < 2; c++) begin
            logic fm, fb, ok;
            fm = fell_m(c[0], mk2[c], mk1[c], mk);
            fb = fell_m(c[0], bk2[c], bk1[c], bk);
            ok = mk | bk;
            m_pr[c] = 1'b0; m_rl[c] = 1'b0;
            if (ok && !m_st[c] && fm) begin m_st[c] = 1'b1; m_pr[c] = 1'b1; end
            else if (ok && m_st[c] && fb) begin m_st[c] = 1'b0; m_rl[c] = 1'b1; end
            mk2[c] = mk1[c]; mk1[c] = mk;
            bk2[c] = bk1[c]; bk1[c] = bk;
        end
    endtask

    // One tick period: drive at slot start, check mid-slot and just after the tick.
    task automatic slot(input logic mk, input logic bk, input string tag);
        logic prev [2];
        for (int c = 0; c < 2; c++) prev[c] = m_st[c];
        make_n  = mk;
        break_n = bk;
        model_tick(mk, bk);
        @(posedge clk);
        @(negedge clk);
        for (int c = 0; c < 2; c++) begin
            check(pr[c] | rl[c], 1'b0, "R8", "pulse low between ticks");
            check(act[c], prev[c], "R7", "state steady between ticks");
        end
        repeat (T - 1) @(posedge clk);
        @(negedge clk);
        for (int c = 0; c < 2; c++) begin
            check(act[c], m_st[c], tag, c ? "state (confirm)" : "state");
            check(pr[c], m_pr[c], tag, c ? "press (confirm)" : "press");
            check(rl[c], m_rl[c], tag, c ? "release (confirm)" : "release");
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        for (int c = 0; c < 2; c++) begin
            check(act[c], 1'b0, "R1", "state in reset");
            check(pr[c] | rl[c], 1'b0, "R1", "pulses in reset");
        end
        rst = 1'b0;

        // R1: resting levels hold state
        slot(1'b1, 1'b0, "R1");
        // R2: make contact falls; plain unit presses, confirm unit waits
        slot(1'b1, 1'b1, "R2");
        slot(1'b0, 1'b1, "R2");
        check(act[0], 1'b1, "R2", "plain press taken");
        check(act[1], 1'b0, "R6", "confirm waits one more tick");
        slot(1'b0, 1'b1, "R6");
        check(act[1], 1'b1, "R6", "confirm press after second low");
        // R4: make bounce while pressed ignored
        slot(1'b1, 1'b1, "R4");
        slot(1'b0, 1'b1, "R4");
        slot(1'b0, 1'b1, "R4");
        check(act[0] & act[1], 1'b1, "R4", "bounce on make ignored");
        // R3: break contact falls
        slot(1'b1, 1'b1, "R3");
        slot(1'b1, 1'b0, "R3");
        check(act[0], 1'b0, "R3", "plain release taken");
        slot(1'b1, 1'b0, "R3");
        check(act[1], 1'b0, "R3", "confirm release taken");
        // R5: both low with a make fall is discarded
        slot(1'b1, 1'b1, "R5");
        slot(1'b0, 1'b0, "R5");
        check(act[0], 1'b0, "R5", "both low ignored");
        // R6: single low sample rejected in confirm mode
        slot(1'b1, 1'b1, "R6");
        slot(1'b1, 1'b1, "R6");
        slot(1'b0, 1'b1, "R6");
        slot(1'b1, 1'b1, "R6");
        check(act[1], 1'b0, "R6", "single low rejected");

        // random mix
        for (int n = 0; n < 400; n++) begin
            logic a, b;
            a = 1'($urandom_range(0, 1));
            b = 1'($urandom_range(0, 1));
            slot(a, b, (a | b) ? "R4" : "R5");
        end

        finish_run();
    end
endmodule